// File: doc/BRIEF.md
# PCIe Link Bring-Up Sequencer

This block walks a root-port core through link training once it receives a single start pulse. It drives the core's configuration registers through a simple request/acknowledge register master. First it caps the advertised maximum link speed at first generation and enables the link training state machine. It then polls a link-up input. Once the link is up, it raises the speed cap to second generation and requests a directed speed change. It waits for the core to clear the speed-change request bit, and then waits for link-up a second time.

The run ends with a held result: a done flag, a pass flag and, on success, the negotiated speed code read back from the core's link status register. On failure the training enable is dropped. Each field update is a read-modify-write that preserves every other bit of the register. The poll count limit and the spacing between polls are parameters.

Top module: `pcie_link_bringup`

## Requirements
- R1: After start, the block reads the register at address 0x07C and writes it back with bits 3:0 set to 1 and all other bits unchanged. The training enable rises in the cycle after that write is acknowledged, and never earlier.
- R2: The first link wait samples the link-up input at most POLL_LIMIT times, spaced POLL_GAP+1 cycles apart. If all samples are low, the run ends with done=1, pass=0, speed=0, training enable low, and no further register access.
- R3: Once the link is up, address 0x07C is read and rewritten with bits 3:0 set to 2 and all other bits unchanged, while the training enable stays high.
- R4: The block then reads address 0x80C and writes it back with bit 17 set and all other bits unchanged.
- R5: The block then reads address 0x80C repeatedly until bit 17 reads 0, for at most POLL_LIMIT reads. A clear bit on the last allowed read still continues the run. If bit 17 is still set on every read, the run fails.
- R6: After the speed change completes, a second link wait with the same limits as R2 runs. If the link does not return, the run fails.
- R7: On success, the block reads address 0x080 once, reports bits 19:16 of the value on speed, and sets pass=1 together with done=1. The training enable stays high.
- R8: A start pulse while a run is in progress is ignored. The run neither restarts nor ends early.
- R9: Done, pass and speed hold their values until the next start. That start clears done in the following cycle.
- R10: The register master keeps at most one access outstanding. It holds request, write, address and write data stable until acknowledge.
- R11: After reset, done, pass, speed, training enable and request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a bring-up run |
| link_up | input | 1 | Link-up indication from the core |
| ltssm_en | output | 1 | Enable for the core's link training state machine |
| bus_req | output | 1 | Register access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register byte address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack on reads |
| bus_ack | input | 1 | Access complete, one cycle |
| done | output | 1 | Run finished (held) |
| pass | output | 1 | Run succeeded (held) |
| speed | output | 4 | Negotiated speed code on success, else 0 |

## Verification
The hardest situations to reach are the poll boundaries: the speed-change bit clearing on exactly the last permitted read, and the link dropping after a successful speed change. The bench's register model counts down a programmable number of reads before it clears bit 17, or keeps the bit stuck. Its link model can be told to withhold link-up only after the speed-change write. With these controls each boundary can be placed exactly where it is wanted, and the number of poll reads can be counted at the bus.

// File: rtl/pcie_link_bringup.sv
module pcie_link_bringup #(
  parameter int POLL_LIMIT = 200,
  parameter int POLL_GAP   = 5000,
  parameter int AW         = 12,
  parameter int DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_up,
  output logic          ltssm_en,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          done,
  output logic          pass,
  output logic [3:0]    speed
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam logic [AW-1:0] A_CAP = AW'(12'h07C);
  localparam logic [AW-1:0] A_CTL = AW'(12'h80C);
  localparam logic [AW-1:0] A_STS = AW'(12'h080);
  localparam int SC_BIT = 17;
  localparam int STS_LO = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_CAP_RD1, S_CAP_WR1, S_LINK1, S_CAP_RD2, S_CAP_WR2,
    S_SC_RD, S_SC_WR, S_SC_POLL, S_SC_GAP, S_LINK2, S_STS_RD
  } st_t;

  st_t           st;
  logic [DW-1:0] tmp;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;

  wire last_poll = (cnt == CW'(POLL_LIMIT - 1));
  wire in_link   = (st == S_LINK1) || (st == S_LINK2);

  always_comb begin
    bus_req   = 1'b1;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_CAP_RD1, S_CAP_RD2: bus_addr = A_CAP;
      S_CAP_WR1: begin
        bus_wr = 1'b1; bus_addr = A_CAP; bus_wdata = {tmp[DW-1:4], 4'd1};
      end
      S_CAP_WR2: begin
        bus_wr = 1'b1; bus_addr = A_CAP; bus_wdata = {tmp[DW-1:4], 4'd2};
      end
      S_SC_RD, S_SC_POLL: bus_addr = A_CTL;
      S_SC_WR: begin
        bus_wr = 1'b1; bus_addr = A_CTL; bus_wdata = tmp | (DW'(1) << SC_BIT);
      end
      S_STS_RD: bus_addr = A_STS;
      default: bus_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmp      <= '0;
      cnt      <= '0;
      gap      <= '0;
      ltssm_en <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      speed    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_CAP_RD1;
          done     <= 1'b0;
          pass     <= 1'b0;
          speed    <= '0;
          ltssm_en <= 1'b0;
        end
        S_CAP_RD1: if (bus_ack) begin tmp <= bus_rdata; st <= S_CAP_WR1; end
        S_CAP_WR1: if (bus_ack) begin
          ltssm_en <= 1'b1;
          cnt      <= '0;
          gap      <= '0;
          st       <= S_LINK1;
        end
        S_CAP_RD2: if (bus_ack) begin tmp <= bus_rdata; st <= S_CAP_WR2; end
        S_CAP_WR2: if (bus_ack) st <= S_SC_RD;
        S_SC_RD:   if (bus_ack) begin tmp <= bus_rdata; st <= S_SC_WR; end
        S_SC_WR:   if (bus_ack) begin cnt <= '0; st <= S_SC_POLL; end
        S_SC_POLL: if (bus_ack) begin
          if (!bus_rdata[SC_BIT]) begin
            cnt <= '0;
            gap <= '0;
            st  <= S_LINK2;
          end else if (last_poll) begin
            done <= 1'b1; pass <= 1'b0; ltssm_en <= 1'b0; st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            gap <= GW'(POLL_GAP);
            st  <= S_SC_GAP;
          end
        end
        S_SC_GAP:
          if (gap != '0) gap <= gap - 1'b1;
          else st <= S_SC_POLL;
        S_STS_RD: if (bus_ack) begin
          speed <= bus_rdata[STS_LO +: 4];
          pass  <= 1'b1;
          done  <= 1'b1;
          st    <= S_IDLE;
        end
        default: if (in_link) begin
          if (gap != '0) gap <= gap - 1'b1;
          else if (link_up) st <= (st == S_LINK1) ? S_CAP_RD2 : S_STS_RD;
          else if (last_poll) begin
            done <= 1'b1; pass <= 1'b0; ltssm_en <= 1'b0; st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            gap <= GW'(POLL_GAP);
          end
        end else st <= S_IDLE;
      endcase
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)); // R10
  AST_LTSSM_AFTER_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en) |-> $past(bus_ack && bus_wr && bus_addr == A_CAP && bus_wdata[3:0] == 4'd1)); // R1
  AST_GEN2_WITH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_wr && bus_addr == A_CAP && bus_wdata[3:0] == 4'd2 |-> ltssm_en); // R3
  AST_FAIL_SPEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass |-> speed == 4'd0 && !ltssm_en); // R2
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && ltssm_en); // R7
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !done); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(speed)); // R9

endmodule

// File: tb/test_pcie_link_bringup.sv
module test_pcie_link_bringup;
  localparam int LIM = 12;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, link_up = 1'b0;
  logic ltssm_en, bus_req, bus_wr, bus_ack, done, pass;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0] speed;

  always #10 clk = ~clk;

  pcie_link_bringup #(.POLL_LIMIT(LIM), .POLL_GAP(GAP), .AW(12), .DW(32)) i_pcie_link_bringup (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up), .ltssm_en(ltssm_en),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done), .pass(pass), .speed(speed));

  int n_tests = 0, n_fail = 0;

  logic [31:0] cap_reg, ctl_reg, sts_reg;
  int sc_left, cap_wr_n, ctl_rd_n, sts_rd_n, acc_n, up_cnt;
  logic sc_stuck, link1_ok, link2_ok, sc_written, ltssm_at_w1, lat;
  logic [31:0] cap_w1, cap_w2, ctl_w;

  always @(posedge clk) begin
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      if (!lat) lat <= 1'b1;
      else begin
        lat <= 1'b0;
        bus_ack <= 1'b1;
        acc_n <= acc_n + 1;
        if (bus_wr) begin
          case (bus_addr)
            12'h07C: begin
              cap_reg <= bus_wdata;
              if (cap_wr_n == 0) begin cap_w1 <= bus_wdata; ltssm_at_w1 <= ltssm_en; end
              else cap_w2 <= bus_wdata;
              cap_wr_n <= cap_wr_n + 1;
            end
            12'h80C: begin ctl_reg <= bus_wdata; ctl_w <= bus_wdata; sc_written <= 1'b1; end
            default: ;
          endcase
        end else begin
          case (bus_addr)
            12'h07C: bus_rdata <= cap_reg;
            12'h80C: begin
              ctl_rd_n <= ctl_rd_n + 1;
              if (ctl_reg[17] && !sc_stuck && sc_left == 0) begin
                ctl_reg[17] <= 1'b0;
                bus_rdata <= ctl_reg & ~(32'd1 << 17);
              end else begin
                if (ctl_reg[17] && sc_left > 0) sc_left <= sc_left - 1;
                bus_rdata <= ctl_reg;
              end
            end
            12'h080: begin sts_rd_n <= sts_rd_n + 1; bus_rdata <= sts_reg; end
            default: bus_rdata <= 32'hDEAD_BEEF;
          endcase
        end
      end
    end
    if (!ltssm_en) up_cnt <= 0; else up_cnt <= up_cnt + 1;
    link_up <= ltssm_en && up_cnt >= 5 && (sc_written ? link2_ok : link1_ok);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input int sc_n, input bit stuck, input bit l1, input bit l2);
    cap_reg = 32'h5A5A_F3C3; ctl_reg = 32'h0000_012F; sts_reg = 32'h0002_0011;
    sc_left = sc_n; sc_stuck = stuck; link1_ok = l1; link2_ok = l2; sc_written = 1'b0;
    cap_wr_n = 0; ctl_rd_n = 0; sts_rd_n = 0; acc_n = 0; lat = 1'b0;
    cap_w1 = '0; cap_w2 = '0; ctl_w = '0; ltssm_at_w1 = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    chk(!done && !pass && speed == 0 && !ltssm_en && !bus_req, "R11 reset state",
        {done, pass, ltssm_en, bus_req, speed}, 0);
  endtask

  task automatic t_nominal();
    bit ok;
    setup(3, 0, 1, 1);
    pulse_start();
    wait_done(ok);
    chk(ok && pass, "R7 nominal pass", {ok, pass}, 2'b11);
    chk(cap_w1 == 32'h5A5A_F3C1, "R1 gen1 rmw value", cap_w1, 32'h5A5A_F3C1);
    chk(ltssm_at_w1 == 1'b0, "R1 enable low at gen1 write", ltssm_at_w1, 0);
    chk(cap_w2 == 32'h5A5A_F3C2, "R3 gen2 rmw value", cap_w2, 32'h5A5A_F3C2);
    chk(ctl_w == 32'h0002_012F, "R4 speed change rmw value", ctl_w, 32'h0002_012F);
    chk(ctl_rd_n == 5, "R5 poll reads until clear", ctl_rd_n, 5);
    chk(speed == 4'd2 && sts_rd_n == 1, "R7 speed code", speed, 2);
    chk(ltssm_en, "R7 enable stays high", ltssm_en, 1);
  endtask

  task automatic t_link_never();
    bit ok; int a;
    setup(0, 0, 0, 0);
    pulse_start();
    wait_done(ok);
    chk(ok && !pass && speed == 0 && !ltssm_en, "R2 link never up fails",
        {ok, pass, ltssm_en, speed}, 7'b1000000);
    a = acc_n;
    chk(a == 2 && cap_wr_n == 1, "R2 no access after link fail", a, 2);
    repeat (20) @(negedge clk);
    chk(acc_n == a && !bus_req, "R2 bus quiet after fail", acc_n, a);
  endtask

  task automatic t_sc_stuck();
    bit ok;
    setup(0, 1, 1, 1);
    pulse_start();
    wait_done(ok);
    chk(ok && !pass, "R5 stuck speed change fails", pass, 0);
    chk(ctl_rd_n == LIM + 1, "R5 poll limit reads", ctl_rd_n, LIM + 1);
    chk(sts_rd_n == 0, "R5 no status read on fail", sts_rd_n, 0);
  endtask

  task automatic t_sc_last();
    bit ok;
    setup(LIM - 1, 0, 1, 1);
    pulse_start();
    wait_done(ok);
    chk(ok && pass && speed == 2, "R5 clear on last allowed read passes", {pass, speed}, 5'h12);
    chk(ctl_rd_n == LIM + 1, "R5 last read count", ctl_rd_n, LIM + 1);
  endtask

  task automatic t_link2_lost();
    bit ok;
    setup(1, 0, 1, 0);
    pulse_start();
    wait_done(ok);
    chk(ok && !pass && speed == 0, "R6 second link wait fails", {pass, speed}, 0);
    chk(sts_rd_n == 0 && ctl_w[17], "R6 failed after speed change", sts_rd_n, 0);
  endtask

  task automatic t_busy_start();
    bit ok;
    setup(2, 0, 1, 1);
    pulse_start();
    repeat (15) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done(ok);
    chk(ok && pass && cap_wr_n == 2, "R8 start while busy ignored", cap_wr_n, 2);
  endtask

  task automatic t_hold_restart();
    repeat (60) @(negedge clk);
    chk(done && pass && speed == 2, "R9 result held", {done, pass, speed}, 6'h32);
    setup(0, 0, 0, 0);
    pulse_start();
    chk(!done && !pass && speed == 0, "R9 start clears result", {done, pass, speed}, 0);
  endtask

  initial begin
    setup(0, 0, 1, 1);
    bus_ack = 1'b0; bus_rdata = '0; up_cnt = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_link_never();
    t_sc_stuck();
    t_sc_last();
    t_link2_lost();
    t_busy_start();
    t_hold_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule